// File: doc/BRIEF.md
# Alarm-Driven Power-Enable Controller

This block owns the enable line of an external supply regulator. After reset the line is ON. A second alarm comparator elsewhere in the clock domain produces a one-cycle match pulse. When the arm bit in the 32-bit power-control word is set, that pulse switches the enable line OFF. The line then stays OFF until one of four external wakeup pins, qualified by its own enable and polarity bits, reports assertion. The enable line then returns ON.

Every match pulse also sets a sticky alarm status flag, whether or not the arm bit is set. Software clears the flag by writing a one to its bit of the status byte. The flag is gated by an interrupt-enable bit to form the alarm interrupt. A separate one-cycle wake event marks each moment at which the set of qualified wakeup pins goes from none active to at least one active.

Top module: `alarm_power_ctl`

## Requirements
- R1: After reset `pwrEnable` is 1 and `alarm2Status`, `alarm2Irq` and `wakeEvent` are 0.
- R2: A match pulse while bit 16 of `ctrlWord` is 1 drives `pwrEnable` to 0 at the next clock edge.
- R3: A match pulse while bit 16 of `ctrlWord` is 0 leaves `pwrEnable` unchanged.
- R4: Every match pulse sets `alarm2Status` at the next edge. The flag holds until a status write (`statusWrEn`=1) with `statusWrData` bit 7 set clears it. A status write with bit 7 clear has no effect. If a set and a clear land in the same cycle, the set wins.
- R5: `alarm2Irq` equals `alarm2Status` AND `intEnable` bit 4.
- R6: Wakeup pin i is active when `ctrlWord` bit i (enable) is 1 and its level XOR `ctrlWord` bit 4+i (polarity) is 1. Polarity 1 means active low and polarity 0 means active high. A pin whose enable bit is 0 never counts.
- R7: While `pwrEnable` is 0, any active wakeup pin sets `pwrEnable` to 1 at the next edge.
- R8: While `pwrEnable` is 0 and no wakeup pin is active, `pwrEnable` stays 0.
- R9: `wakeEvent` is a single-cycle pulse that appears at the edge where the set of active wakeup pins changes from none to at least one.
- R10: If a shutdown match and an active wakeup coincide, the output goes to 0. The wakeup then takes effect at the following edge if it is still active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| alarm2Match | input | 1 | One-cycle match pulse from the second alarm comparator |
| ctrlWord | input | 32 | Power-control word: bits 0-3 wake enables, bits 4-7 polarities, bit 16 arm |
| intEnable | input | 8 | Interrupt-enable byte; bit 4 gates the alarm interrupt |
| statusWrEn | input | 1 | Status byte write strobe |
| statusWrData | input | 8 | Status write data; a 1 in bit 7 clears the alarm flag |
| wakePins | input | 4 | External wakeup pin levels |
| pwrEnable | output | 1 | Regulator enable (1 = ON) |
| wakeEvent | output | 1 | Pulse when a qualified wakeup first becomes active |
| alarm2Status | output | 1 | Sticky alarm flag |
| alarm2Irq | output | 1 | Alarm interrupt request |

## Verification
The bench targets the precedence cases. A match and a clear in the same cycle must leave the flag set; a design that lets the clear win would lose an alarm. A shutdown that coincides with a held wakeup must still produce one OFF cycle; a design that lets the wake win would never turn the supply off. Polarity is exercised with both senses, and a disabled pin is held at its active level. A design that ignores polarity or enable would restore power from an idle or masked pin. The disarmed case checks that a match with bit 16 clear sets only the flag and leaves the supply on.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef struct packed {
    logic shutDown;
    logic wakeUp;
    logic statSet;
    logic statClr;
  } apcStrobes_t;
endpackage

// File: rtl/apc_control.sv
module apc_control
  import apc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        alarm2Match,
  input  logic        armBit,
  input  logic        statusWrEn,
  input  logic        clrBit,
  input  logic        pwrOn,
  input  logic        anyWake,
  output apcStrobes_t strobes
);
  always_comb begin
    strobes.shutDown = alarm2Match && armBit;
    strobes.wakeUp   = !pwrOn && anyWake && !(alarm2Match && armBit);
    strobes.statSet  = alarm2Match;
    strobes.statClr  = statusWrEn && clrBit;
  end

  // R7
  wake_only_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wakeUp |-> !pwrOn);
endmodule

// File: rtl/apc_datapath.sv
module apc_datapath
  import apc_pkg::*;
#(
  parameter int NUM_WAKE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  apcStrobes_t         strobes,
  input  logic [NUM_WAKE-1:0] wakeEn,
  input  logic [NUM_WAKE-1:0] wakePol,
  input  logic [NUM_WAKE-1:0] wakePins,
  output logic                pwrOn,
  output logic                anyWake,
  output logic                wakeEvent,
  output logic                statFlag
);
  logic [NUM_WAKE-1:0] wakeQual;
  logic                wakeAnyQ;

  for (genvar i = 0; i < NUM_WAKE; i++) begin : g_wake
    assign wakeQual[i] = wakeEn[i] & (wakePins[i] ^ wakePol[i]);
  end

  assign anyWake = |wakeQual;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrOn     <= 1'b1;
      statFlag  <= 1'b0;
      wakeAnyQ  <= 1'b0;
      wakeEvent <= 1'b0;
    end else begin
      if (strobes.shutDown)    pwrOn <= 1'b0;
      else if (strobes.wakeUp) pwrOn <= 1'b1;
      if (strobes.statSet)      statFlag <= 1'b1;
      else if (strobes.statClr) statFlag <= 1'b0;
      wakeAnyQ  <= anyWake;
      wakeEvent <= anyWake & ~wakeAnyQ;
    end
  end

  // R2
  pwr_off_after_shutdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shutDown |=> !pwrOn);
  // R7
  pwr_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pwrOn) |-> $past(strobes.wakeUp));
  // R4
  stat_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statFlag) |-> $past(strobes.statSet));
  // R9
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvent |=> !wakeEvent);
endmodule

// File: rtl/alarm_power_ctl.sv
module alarm_power_ctl
  import apc_pkg::*;
#(
  parameter int NUM_WAKE = 4,
  parameter int CTRL_W   = 32,
  parameter int ARM_BIT  = 16,
  parameter int BYTE_W   = 8,
  parameter int CLR_BIT  = 7,
  parameter int IEN_BIT  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                alarm2Match,
  input  logic [CTRL_W-1:0]   ctrlWord,
  input  logic [BYTE_W-1:0]   intEnable,
  input  logic                statusWrEn,
  input  logic [BYTE_W-1:0]   statusWrData,
  input  logic [NUM_WAKE-1:0] wakePins,
  output logic                pwrEnable,
  output logic                wakeEvent,
  output logic                alarm2Status,
  output logic                alarm2Irq
);
  localparam int POL_BASE = NUM_WAKE;

  apcStrobes_t strobes;
  logic        pwrOn;
  logic        anyWake;
  logic        statFlag;
  logic        unusedBits;

  assign unusedBits = ^{ctrlWord, intEnable, statusWrData};

  apc_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .alarm2Match(alarm2Match),
    .armBit     (ctrlWord[ARM_BIT]),
    .statusWrEn (statusWrEn),
    .clrBit     (statusWrData[CLR_BIT]),
    .pwrOn      (pwrOn),
    .anyWake    (anyWake),
    .strobes    (strobes)
  );

  apc_datapath #(.NUM_WAKE(NUM_WAKE)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wakeEn   (ctrlWord[NUM_WAKE-1:0]),
    .wakePol  (ctrlWord[POL_BASE+NUM_WAKE-1:POL_BASE]),
    .wakePins (wakePins),
    .pwrOn    (pwrOn),
    .anyWake  (anyWake),
    .wakeEvent(wakeEvent),
    .statFlag (statFlag)
  );

  assign pwrEnable    = pwrOn;
  assign alarm2Status = statFlag;
  assign alarm2Irq    = statFlag & intEnable[IEN_BIT];
endmodule

// File: tb/sim_alarm_power_ctl.sv
module sim_alarm_power_ctl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        alarm2Match = 1'b0;
  logic [31:0] ctrlWord = 32'h0000_00F0;
  logic [7:0]  intEnable = 8'h00;
  logic        statusWrEn = 1'b0;
  logic [7:0]  statusWrData = 8'h00;
  logic [3:0]  wakePins = 4'hF;
  logic        pwrEnable, wakeEvent, alarm2Status, alarm2Irq;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alarm_power_ctl u0 (
    .clk(clk), .rstN(rstN), .alarm2Match(alarm2Match), .ctrlWord(ctrlWord),
    .intEnable(intEnable), .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .wakePins(wakePins), .pwrEnable(pwrEnable), .wakeEvent(wakeEvent),
    .alarm2Status(alarm2Status), .alarm2Irq(alarm2Irq)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doReset(input logic [31:0] cw, input logic [3:0] pins);
    @(negedge clk);
    rstN = 1'b0; alarm2Match = 1'b0; statusWrEn = 1'b0; statusWrData = 8'h00;
    intEnable = 8'h00; ctrlWord = cw; wakePins = pins;
    tick(); tick();
    @(negedge clk); rstN = 1'b1;
    tick();
  endtask

  task automatic pulseMatch();
    @(negedge clk); alarm2Match = 1'b1;
    tick();
    @(negedge clk); alarm2Match = 1'b0;
  endtask

  task automatic testReset();
    doReset(32'h0000_00F0, 4'hF);
    check("R1", "pwrEnable", pwrEnable, 1'b1);
    check("R1", "alarm2Status", alarm2Status, 1'b0);
    check("R1", "alarm2Irq", alarm2Irq, 1'b0);
    check("R1", "wakeEvent", wakeEvent, 1'b0);
  endtask

  task automatic testDisarmed();
    doReset(32'h0000_00F0, 4'hF);
    @(negedge clk); alarm2Match = 1'b1;
    tick();
    check("R3", "pwrEnable stays on", pwrEnable, 1'b1);
    check("R4", "status set", alarm2Status, 1'b1);
    check("R5", "irq masked", alarm2Irq, 1'b0);
    @(negedge clk); alarm2Match = 1'b0; intEnable = 8'h10; #1;
    check("R5", "irq enabled", alarm2Irq, 1'b1);
    intEnable = 8'hEF; #1;
    check("R5", "other enable bits", alarm2Irq, 1'b0);
    intEnable = 8'h10;
    statusWrEn = 1'b1; statusWrData = 8'h7F;
    tick();
    check("R4", "write without bit7 ignored", alarm2Status, 1'b1);
    @(negedge clk); statusWrData = 8'h80;
    tick();
    check("R4", "write 1 clears", alarm2Status, 1'b0);
    check("R5", "irq follows clear", alarm2Irq, 1'b0);
    @(negedge clk); statusWrEn = 1'b0;
  endtask

  task automatic testSetWins();
    doReset(32'h0000_00F0, 4'hF);
    @(negedge clk); alarm2Match = 1'b1; statusWrEn = 1'b1; statusWrData = 8'h80;
    tick();
    check("R4", "set beats clear", alarm2Status, 1'b1);
    @(negedge clk); alarm2Match = 1'b0; statusWrEn = 1'b0;
  endtask

  task automatic testShutdownWake();
    doReset(32'h0001_00F1, 4'hF);
    @(negedge clk); alarm2Match = 1'b1;
    tick();
    check("R2", "armed match turns off", pwrEnable, 1'b0);
    @(negedge clk); alarm2Match = 1'b0;
    tick(); tick();
    check("R8", "stays off idle", pwrEnable, 1'b0);
    @(negedge clk); wakePins = 4'b1101;
    tick(); tick();
    check("R6", "disabled pin ignored", pwrEnable, 1'b0);
    check("R9", "no event from disabled pin", wakeEvent, 1'b0);
    @(negedge clk); wakePins = 4'b1100;
    tick();
    check("R7", "active-low pin restores", pwrEnable, 1'b1);
    check("R9", "event pulse", wakeEvent, 1'b1);
    tick();
    check("R9", "event one cycle", wakeEvent, 1'b0);
    check("R7", "stays on", pwrEnable, 1'b1);
  endtask

  task automatic testPolarity();
    doReset(32'h0001_00B4, 4'b1011);
    pulseMatch();
    check("R2", "off before polarity test", pwrEnable, 1'b0);
    tick();
    check("R6", "active-high pin idle low", pwrEnable, 1'b0);
    @(negedge clk); wakePins = 4'b1111;
    tick();
    check("R6", "active-high pin restores", pwrEnable, 1'b1);
    check("R9", "event on active-high", wakeEvent, 1'b1);
  endtask

  task automatic testRace();
    doReset(32'h0001_00F1, 4'b1110);
    check("R7", "held wake keeps on", pwrEnable, 1'b1);
    @(negedge clk); alarm2Match = 1'b1;
    tick();
    check("R10", "shutdown wins", pwrEnable, 1'b0);
    @(negedge clk); alarm2Match = 1'b0;
    tick();
    check("R10", "held wake restores", pwrEnable, 1'b1);
  endtask

  initial begin
    testReset();
    testDisarmed();
    testSetWins();
    testShutdownWake();
    testPolarity();
    testRace();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule